// File: doc/BRIEF.md
# Multi-Period Dwell Time Sequencer

This block walks a data-collection system through a programmed series of dwell periods. A 64-entry table holds one 16-bit length per period, counted in base ticks. A configuration register picks the number of periods in use and the size of the base tick: 1 ms, 10 ms or 100 ms. The ticks come from a prescaler on the system clock and a chain of decade dividers.

After a start command the block counts base ticks in the current period. When a period expires it moves to the next period and pulses a count strobe, so that external spectrum counters step forward. It also emits a period-end strobe that carries the index of the period just finished, for a scaler snapshot block. When the last period expires a stop latch sets and a complementary pair of veto outputs changes state. The pair holds until the next start.

A halt command freezes all counters and a later start resumes from the frozen point. A clear request made while halted holds the block and the external counters at the first period. The next start drops the clear and begins a fresh sweep.

Top module: `dwell_sequencer`

## Requirements
- R1: After reset the sequencer is halted with running=0, veto=0, vetoN=1, clearOut=0, countPulse=0, periodEnd=0, tblRdValid=0 and curIdx=0. The configuration resets to lastIdx=0 and tickSel=0.
- R2: A cfgWrite while halted loads cfgLastIdx, which is the number of periods minus one (0 gives 1 period, 63 gives 64), and cfgTickSel. A cfgWrite while running is ignored.
- R3: The base tick lasts TICKS_PER_MS clock cycles of running time for tickSel codes 0 and 3, ten times that for code 1, and a hundred times that for code 2.
- R4: Periods run in order from index 0 up to lastIdx. Period i lasts table[i] base ticks. When it ends, periodEnd pulses for one cycle with periodEndIdx=i.
- R5: countPulse is a one-cycle pulse in the same cycle as periodEnd, for every period except the last one. It never appears without periodEnd.
- R6: When the last period ends, running drops, veto goes to 1 and vetoN to 0, all in the same cycle as that period's periodEnd. They stay that way until the next accepted start.
- R7: While halted, tblWrite stores tblWrData at tblAddr. tblRead returns that entry on tblRdData, with tblRdValid high, one cycle later. While running, both requests are ignored.
- R8: A clearSet while halted raises clearOut and holds curIdx and the dwell timing at the start of period 0. An accepted start drops clearOut. A clearSet while running is ignored.
- R9: A haltCmd stops tick and period counting without losing state. curIdx stays stable while halted, and a later start continues the remaining dwell where it stopped.
- R10: After the last period, the index and the dwell timing return to the start of period 0, so the next start without a clear begins a new full sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| goCmd | input | 1 | Start/resume request; halt wins if both are high |
| haltCmd | input | 1 | Halt request |
| clearSet | input | 1 | Request the clear state (honoured while halted) |
| cfgWrite | input | 1 | Load period count and tick select |
| cfgLastIdx | input | 6 | Number of periods minus one |
| cfgTickSel | input | 2 | Base tick code: 0/3 = 1 ms, 1 = 10 ms, 2 = 100 ms |
| tblWrite | input | 1 | Table write strobe |
| tblRead | input | 1 | Table read strobe |
| tblAddr | input | 6 | Table entry index |
| tblWrData | input | 16 | Dwell length to store, in base ticks |
| tblRdData | output | 16 | Table read data |
| tblRdValid | output | 1 | Read data valid, one cycle after tblRead |
| running | output | 1 | Sequencer is counting |
| curIdx | output | 6 | Current period index |
| countPulse | output | 1 | Advance strobe for external spectrum counters |
| periodEnd | output | 1 | Period finished strobe |
| periodEndIdx | output | 6 | Index of the period that just finished |
| veto | output | 1 | High once the last period has ended |
| vetoN | output | 1 | Complement of veto |
| clearOut | output | 1 | Clear hold for external counters |

## Verification
Each period boundary is due on the clock edge where the number of edges that saw running high, counted from the start edge, reaches the running sum of table[i]·TICKS_PER_MS·scale. The bench keeps that count of active edges itself by sampling running on the falling edge before each rising edge, so time spent halted adds nothing. Strobes, veto and curIdx are all registered and are checked on the falling edge right after the edge that produced them. Table reads, clear requests and configuration writes are checked one cycle after they are issued. Sweeps cover every tick code, single and 64-period configurations, a halt and resume in mid-period, and a fresh sweep after a clear.

// File: rtl/dwell_pkg.sv
`timescale 1ns/1ps
package dwell_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic step;     // move to next period, restart dwell
    logic restart;  // return to period 0, dwell at zero
    logic tblWe;    // accepted table write
    logic tblRe;    // accepted table read
  } seqStrobe_t;

  typedef enum logic [1:0] {
    TICK_MS_A   = 2'd0,
    TICK_10MS   = 2'd1,
    TICK_100MS  = 2'd2,
    TICK_MS_B   = 2'd3
  } tickSel_e;
endpackage

// File: rtl/dwell_tick_gen.sv
`timescale 1ns/1ps
module dwell_tick_gen #(
  parameter int TICKS_PER_MS = 200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       restart,
  input  logic [1:0] tickSel,
  output logic       baseTick
);
  import dwell_pkg::*;

  localparam int DECADES = 2;
  localparam int PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PW-1:0] PMAX = PW'(TICKS_PER_MS - 1);

  logic [PW-1:0] presc;
  logic [DECADES:0] stageTick;

  assign stageTick[0] = enable && (presc == PMAX);

  always_ff @(posedge clk) begin
    if (!rstN)           presc <= '0;
    else if (restart)    presc <= '0;
    else if (enable)     presc <= stageTick[0] ? '0 : presc + 1'b1;
  end

  generate
    for (genvar s = 0; s < DECADES; s++) begin : g_decade
      logic [3:0] dec;
      always_ff @(posedge clk) begin
        if (!rstN)              dec <= '0;
        else if (restart)       dec <= '0;
        else if (stageTick[s])  dec <= (dec == 4'd9) ? 4'd0 : dec + 4'd1;
      end
      assign stageTick[s+1] = stageTick[s] && (dec == 4'd9);
    end
  endgenerate

  always_comb begin
    unique case (tickSel_e'(tickSel))
      TICK_10MS:  baseTick = stageTick[1];
      TICK_100MS: baseTick = stageTick[2];
      default:    baseTick = stageTick[0];
    endcase
  end
endmodule

// File: rtl/dwell_datapath.sv
`timescale 1ns/1ps
module dwell_datapath
  import dwell_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             baseTick,
  input  logic [IDX_W-1:0] tblAddr,
  input  logic [DW-1:0]    tblWrData,
  output logic [DW-1:0]    tblRdData,
  output logic             tblRdValid,
  output logic [IDX_W-1:0] curIdx,
  output logic             expire
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] dwellMem [DEPTH];
  logic [DW-1:0] elapsed;
  logic [DW-1:0] dwellNow;

  always_ff @(posedge clk) begin
    if (strb.tblWe) dwellMem[tblAddr] <= tblWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblRdData  <= '0;
      tblRdValid <= 1'b0;
    end else begin
      tblRdValid <= strb.tblRe;
      if (strb.tblRe) tblRdData <= dwellMem[tblAddr];
    end
  end

  assign dwellNow = dwellMem[curIdx];
  // a zero entry wraps, giving the longest possible dwell
  assign expire = baseTick && (elapsed == dwellNow - DW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx  <= '0;
      elapsed <= '0;
    end else if (strb.restart) begin
      curIdx  <= '0;
      elapsed <= '0;
    end else if (strb.step) begin
      curIdx  <= curIdx + 1'b1;
      elapsed <= '0;
    end else if (baseTick) begin
      elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/dwell_control.sv
`timescale 1ns/1ps
module dwell_control
  import dwell_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goCmd,
  input  logic             haltCmd,
  input  logic             clearSet,
  input  logic             cfgWrite,
  input  logic [IDX_W-1:0] cfgLastIdx,
  input  logic [1:0]       cfgTickSel,
  input  logic             tblWrite,
  input  logic             tblRead,
  input  logic             expire,
  input  logic [IDX_W-1:0] curIdx,
  output seqStrobe_t       strb,
  output logic             running,
  output logic             stopLatch,
  output logic             clearState,
  output logic [1:0]       tickSel,
  output logic             countPulse,
  output logic             periodEnd,
  output logic [IDX_W-1:0] periodEndIdx
);
  logic [IDX_W-1:0] lastIdx;
  logic goAcc, clearAcc, expireNow, finalNow;

  assign goAcc     = goCmd && !haltCmd && !running;
  assign clearAcc  = clearSet && !running;
  assign expireNow = running && expire;
  assign finalNow  = expireNow && (curIdx == lastIdx);

  always_comb begin
    strb.step    = expireNow && !finalNow;
    strb.restart = finalNow || clearState || clearAcc;
    strb.tblWe   = tblWrite && !running;
    strb.tblRe   = tblRead && !running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running      <= 1'b0;
      stopLatch    <= 1'b0;
      clearState   <= 1'b0;
      lastIdx      <= '0;
      tickSel      <= 2'd0;
      countPulse   <= 1'b0;
      periodEnd    <= 1'b0;
      periodEndIdx <= '0;
    end else begin
      if (haltCmd)       running <= 1'b0;
      else if (goAcc)    running <= 1'b1;
      else if (finalNow) running <= 1'b0;

      if (goAcc)         stopLatch <= 1'b0;
      else if (finalNow) stopLatch <= 1'b1;

      if (goAcc)         clearState <= 1'b0;
      else if (clearAcc) clearState <= 1'b1;

      if (cfgWrite && !running) begin
        lastIdx <= cfgLastIdx;
        tickSel <= cfgTickSel;
      end

      countPulse <= strb.step;
      periodEnd  <= expireNow;
      if (expireNow) periodEndIdx <= curIdx;
    end
  end
endmodule

// File: rtl/dwell_sequencer.sv
`timescale 1ns/1ps
module dwell_sequencer #(
  parameter int TICKS_PER_MS = 200000,
  parameter int IDX_W        = 6,
  parameter int DW           = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goCmd,
  input  logic             haltCmd,
  input  logic             clearSet,
  input  logic             cfgWrite,
  input  logic [IDX_W-1:0] cfgLastIdx,
  input  logic [1:0]       cfgTickSel,
  input  logic             tblWrite,
  input  logic             tblRead,
  input  logic [IDX_W-1:0] tblAddr,
  input  logic [DW-1:0]    tblWrData,
  output logic [DW-1:0]    tblRdData,
  output logic             tblRdValid,
  output logic             running,
  output logic [IDX_W-1:0] curIdx,
  output logic             countPulse,
  output logic             periodEnd,
  output logic [IDX_W-1:0] periodEndIdx,
  output logic             veto,
  output logic             vetoN,
  output logic             clearOut
);
  import dwell_pkg::*;

  seqStrobe_t strb;
  logic       baseTick;
  logic       expire;
  logic       stopLatch;
  logic       clearState;
  logic [1:0] tickSel;

  dwell_tick_gen #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (running),
    .restart  (strb.restart),
    .tickSel  (tickSel),
    .baseTick (baseTick)
  );

  dwell_control #(.IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .goCmd        (goCmd),
    .haltCmd      (haltCmd),
    .clearSet     (clearSet),
    .cfgWrite     (cfgWrite),
    .cfgLastIdx   (cfgLastIdx),
    .cfgTickSel   (cfgTickSel),
    .tblWrite     (tblWrite),
    .tblRead      (tblRead),
    .expire       (expire),
    .curIdx       (curIdx),
    .strb         (strb),
    .running      (running),
    .stopLatch    (stopLatch),
    .clearState   (clearState),
    .tickSel      (tickSel),
    .countPulse   (countPulse),
    .periodEnd    (periodEnd),
    .periodEndIdx (periodEndIdx)
  );

  dwell_datapath #(.IDX_W(IDX_W), .DW(DW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .baseTick   (baseTick),
    .tblAddr    (tblAddr),
    .tblWrData  (tblWrData),
    .tblRdData  (tblRdData),
    .tblRdValid (tblRdValid),
    .curIdx     (curIdx),
    .expire     (expire)
  );

  assign veto     = stopLatch;
  assign vetoN    = !stopLatch;
  assign clearOut = clearState;
endmodule

// File: rtl/dwell_sequencer_chk.sv
`timescale 1ns/1ps
module dwell_sequencer_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             goCmd,
  input logic             haltCmd,
  input logic             clearSet,
  input logic             tblRead,
  input logic             running,
  input logic             veto,
  input logic             countPulse,
  input logic             periodEnd,
  input logic             clearOut,
  input logic             tblRdValid,
  input logic [IDX_W-1:0] curIdx
);
  p_count_with_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> periodEnd);

  p_veto_rise_final_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(veto) |-> (periodEnd && !countPulse && !running));

  p_veto_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (veto && !goCmd) |=> veto);

  p_veto_drops_on_go_r6: assert property (@(posedge clk) disable iff (!rstN)
    (veto && goCmd && !haltCmd) |=> (!veto && running));

  p_busy_read_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (running && tblRead) |=> !tblRdValid);

  p_clear_first_period_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearOut |-> (curIdx == '0));

  p_clear_ignored_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (running && clearSet && !clearOut) |=> !clearOut);

  p_halt_freezes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !goCmd && !clearSet) |=> $stable(curIdx));
endmodule

bind dwell_sequencer dwell_sequencer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .goCmd      (goCmd),
  .haltCmd    (haltCmd),
  .clearSet   (clearSet),
  .tblRead    (tblRead),
  .running    (running),
  .veto       (veto),
  .countPulse (countPulse),
  .periodEnd  (periodEnd),
  .clearOut   (clearOut),
  .tblRdValid (tblRdValid),
  .curIdx     (curIdx)
);

// File: tb/tb_dwell_sequencer.sv
`timescale 1ns/1ps
module tb_dwell_sequencer;
  localparam int TPM = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic goCmd = 0, haltCmd = 0, clearSet = 0, cfgWrite = 0, tblWrite = 0, tblRead = 0;
  logic [5:0] cfgLastIdx = '0, tblAddr = '0;
  logic [1:0] cfgTickSel = '0;
  logic [15:0] tblWrData = '0;
  logic [15:0] tblRdData;
  logic tblRdValid, running, countPulse, periodEnd, veto, vetoN, clearOut;
  logic [5:0] curIdx, periodEndIdx;

  dwell_sequencer #(.TICKS_PER_MS(TPM)) dut (
    .clk(clk), .rstN(rstN), .goCmd(goCmd), .haltCmd(haltCmd), .clearSet(clearSet),
    .cfgWrite(cfgWrite), .cfgLastIdx(cfgLastIdx), .cfgTickSel(cfgTickSel),
    .tblWrite(tblWrite), .tblRead(tblRead), .tblAddr(tblAddr), .tblWrData(tblWrData),
    .tblRdData(tblRdData), .tblRdValid(tblRdValid), .running(running), .curIdx(curIdx),
    .countPulse(countPulse), .periodEnd(periodEnd), .periodEndIdx(periodEndIdx),
    .veto(veto), .vetoN(vetoN), .clearOut(clearOut)
  );

  int checks = 0;
  int fails  = 0;
  int tbl [64];
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic cfg(input int last, input int sel);
    @(negedge clk);
    cfgWrite = 1; cfgLastIdx = 6'(last); cfgTickSel = 2'(sel);
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic readEntry(input int idx, input int expVal, input string tag);
    @(negedge clk);
    tblRead = 1; tblAddr = 6'(idx);
    @(negedge clk);
    tblRead = 0;
    check(tblRdValid == 1'b1, {tag, " read valid"}, tblRdValid, 1);
    check(tblRdData == 16'(expVal), {tag, " read data"}, tblRdData, expVal);
  endtask

  // Runs one sweep from a go command; expected boundaries from the table.
  task automatic sweep(input int last, input int scale, input int haltAt,
                       input int haltLen, input bit poke, input string tag);
    longint ends [64];
    longint cum = 0;
    longint act = 0;
    int e = 0;
    bit wasRun, halted = 0, resumed = 0, pokeDone = 0, pokeChecked = 0;
    int hold = 0;
    logic [5:0] idxSnap = '0;
    for (int i = 0; i <= last; i++) begin
      cum += longint'(tbl[i]) * TPM * scale;
      ends[i] = cum;
    end
    @(negedge clk);
    goCmd = 1;
    @(negedge clk);
    goCmd = 0;
    check(running == 1'b1 && veto == 1'b0 && vetoN == 1'b1, {tag, " R6 go releases veto"},
          {running, veto, vetoN}, 3'b101);
    check(clearOut == 1'b0, {tag, " R8 go drops clear"}, clearOut, 0);
    for (longint c = 0; c < cum + haltLen + 100 && e <= last; c++) begin
      wasRun = running;
      if (poke && !pokeDone && act == 2) begin
        tblWrite = 1; tblRead = 1; tblAddr = 0; tblWrData = 16'hBEEF;
        cfgWrite = 1; cfgLastIdx = 0; cfgTickSel = 2;
        pokeDone = 1;
      end
      if (haltAt > 0 && !halted && act == haltAt) begin
        haltCmd = 1;
        halted = 1;
      end else if (halted && !resumed && hold == haltLen) begin
        check(curIdx == idxSnap, {tag, " R9 index frozen while halted"}, curIdx, idxSnap);
        goCmd = 1;
        resumed = 1;
      end
      @(negedge clk);
      if (wasRun) act++;
      goCmd = 0; haltCmd = 0; tblWrite = 0; tblRead = 0; cfgWrite = 0;
      if (pokeDone && !pokeChecked) begin
        check(tblRdValid == 1'b0, {tag, " R7 read ignored while running"}, tblRdValid, 0);
        pokeChecked = 1;
      end
      if (halted && !resumed) begin
        if (hold == 0) begin
          check(running == 1'b0, {tag, " R9 halt stops"}, running, 0);
          idxSnap = curIdx;
        end
        hold++;
      end
      if (periodEnd) begin
        check(act == ends[e], {tag, " R4 period end time"}, act, ends[e]);
        check(periodEndIdx == 6'(e), {tag, " R4 period end index"}, periodEndIdx, e);
        check(countPulse == (e != last), {tag, " R5 count pulse"}, countPulse, (e != last));
        e++;
      end else begin
        if (act == ends[e])
          check(1'b0, {tag, " R4 missing period end"}, act, ends[e]);
        if (countPulse)
          check(1'b0, {tag, " R5 count without boundary"}, 1, 0);
      end
    end
    check(e == last + 1, {tag, " R4 all periods seen"}, e, last + 1);
    check(running == 1'b0 && veto == 1'b1 && vetoN == 1'b0, {tag, " R6 stop latch"},
          {running, veto, vetoN}, 3'b010);
    repeat (20) @(negedge clk);
    check(veto == 1'b1 && vetoN == 1'b0 && running == 1'b0, {tag, " R6 veto held"},
          {running, veto, vetoN}, 3'b010);
    check(curIdx == 6'd0, {tag, " R10 index back at first period"}, curIdx, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(running == 0 && veto == 0 && vetoN == 1 && clearOut == 0, "R1 reset outputs",
          {running, veto, vetoN, clearOut}, 4'b0010);
    check(countPulse == 0 && periodEnd == 0 && tblRdValid == 0 && curIdx == 0,
          "R1 reset strobes", {countPulse, periodEnd, tblRdValid, curIdx}, 0);
    rstN = 1;

    for (int i = 0; i < 64; i++) begin
      tbl[i] = (i % 5) + 1;
      @(negedge clk);
      tblWrite = 1; tblAddr = 6'(i); tblWrData = 16'(tbl[i]);
    end
    @(negedge clk);
    tblWrite = 0;
    readEntry(0, tbl[0], "R7 entry 0");
    readEntry(17, tbl[17], "R7 entry 17");
    readEntry(63, tbl[63], "R7 entry 63");

    cfg(3, 0);
    sweep(3, 1, 0, 0, 1'b1, "R2 R3 code0");
    readEntry(0, tbl[0], "R7 busy write ignored");

    cfg(0, 1);
    sweep(0, 10, 0, 0, 1'b0, "R3 code1 R10");
    cfg(2, 2);
    sweep(2, 100, 0, 0, 1'b0, "R3 code2");
    cfg(1, 3);
    sweep(1, 1, 0, 0, 1'b0, "R3 code3");
    cfg(63, 0);
    sweep(63, 1, 100, 40, 1'b0, "R9 R2 full 64");

    // R8: clear ignored while running, honoured while halted
    cfg(5, 0);
    @(negedge clk); goCmd = 1;
    @(negedge clk); goCmd = 0;
    repeat (10) @(negedge clk);
    clearSet = 1;
    @(negedge clk); clearSet = 0;
    check(clearOut == 1'b0, "R8 clear ignored while running", clearOut, 0);
    haltCmd = 1;
    @(negedge clk); haltCmd = 0;
    check(curIdx != 6'd0, "R9 halted mid sweep", curIdx, 1);
    clearSet = 1;
    @(negedge clk); clearSet = 0;
    check(clearOut == 1'b1, "R8 clear raised", clearOut, 1);
    check(curIdx == 6'd0, "R8 held at first period", curIdx, 0);
    sweep(5, 1, 0, 0, 1'b0, "R8 after clear");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule